// File: doc/BRIEF.md
# Virtual Interrupt Signalling and Acknowledge Unit

This block sits between a virtual CPU interface's pending-interrupt selector and the processing element. Each cycle it is shown the single best pending virtual interrupt (identifier, 8-bit priority, group) together with the virtual interface control fields as plain inputs. From these it decides whether a virtual IRQ or FIQ line is raised, and what identifier an acknowledge or highest-pending read would return.

An acknowledge moves the presented interrupt to active and records its group priority on a small running-priority stack. The top of that stack sets the level a new interrupt must beat to preempt. End-of-interrupt handling comes in two modes. In the combined mode one request drops the running priority and deactivates the interrupt. In the split mode the end-of-interrupt request only drops the priority and a separate deactivate request retires the interrupt. Identifier storage, distribution and the register bank are not part of this block.

Top module: `virq_ack_unit`

## Requirements
- R1: An interrupt is eligible only if `hp_valid` is 1 and `hp_prio` is strictly below `cfg_pmask` (a lower number means a higher priority); otherwise neither line rises and the read value is the all-ones ID (1023 for ID_W=10).
- R2: A group-0 interrupt (`hp_grp`=0) is eligible only when `cfg_en0`=1, and a group-1 interrupt (`hp_grp`=1) only when `cfg_en1`=1.
- R3: An eligible group-0 interrupt raises `fiq` when `cfg_g0_fiq`=1 and `irq` when it is 0; an eligible group-1 interrupt always raises `irq`; the two lines are never high together.
- R4: The read value `resp_id` is 1022 (all-ones minus one) when the eligible interrupt is group 1 and `cfg_ack_g1`=0, and `hp_id` otherwise when eligible; an acknowledge of such a hidden interrupt changes no state.
- R5: The group priority is `hp_prio` with bits [bp:0] cleared. For group 0, bp is `cfg_bp0`. For group 1, bp is `cfg_bp1` when `cfg_cbp`=0, and `cfg_bp0`+1 saturated at 7 when `cfg_cbp`=1.
- R6: An interrupt is eligible only if its group priority is strictly below `run_prio`. `run_prio` is 0xFF when no interrupt is active, including right after reset.
- R7: `ack_req` with an eligible, non-hidden interrupt pulses `act_vld` with `act_id`=`hp_id` in the next cycle. From that cycle on, `run_prio` equals the pushed group priority.
- R8: The stack holds DEPTH entries. While it is full no interrupt is eligible and the read value is the all-ones ID.
- R9: With `cfg_eoi_split`=0, `eoi_req` on a non-empty stack pops the top entry. In the next cycle it pulses `deact_vld` with `deact_id`=`eoi_id`.
- R10: With `cfg_eoi_split`=1, `eoi_req` pops without any deactivation. `dir_req` pulses `deact_vld` with `deact_id`=`dir_id` in the next cycle.
- R11: `dir_req` has no effect when `cfg_eoi_split`=0. `eoi_req` has no effect when the stack is empty.
- R12: When an acknowledge and an end-of-interrupt land in the same cycle, the top entry is popped and the new one pushed. The depth stays the same and `run_prio` becomes the new group priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_valid | input | 1 | A pending interrupt is presented |
| hp_id | input | ID_W | Identifier of the presented interrupt |
| hp_prio | input | 8 | Priority of the presented interrupt |
| hp_grp | input | 1 | Group of the presented interrupt |
| cfg_pmask | input | 8 | Priority mask |
| cfg_bp0 | input | 3 | Group-0 binary point |
| cfg_bp1 | input | 3 | Group-1 binary point |
| cfg_cbp | input | 1 | Group 1 follows the group-0 binary point |
| cfg_g0_fiq | input | 1 | Route group 0 to FIQ |
| cfg_ack_g1 | input | 1 | Reads expose real group-1 IDs |
| cfg_eoi_split | input | 1 | End-of-interrupt drops priority only |
| cfg_en0 | input | 1 | Group-0 enable |
| cfg_en1 | input | 1 | Group-1 enable |
| ack_req | input | 1 | Acknowledge request |
| eoi_req | input | 1 | End-of-interrupt request |
| eoi_id | input | ID_W | Identifier given with the end-of-interrupt |
| dir_req | input | 1 | Deactivate request |
| dir_id | input | ID_W | Identifier given with the deactivate |
| irq | output | 1 | Virtual IRQ line |
| fiq | output | 1 | Virtual FIQ line |
| resp_id | output | ID_W | Value an acknowledge or highest-pending read returns |
| run_prio | output | 8 | Current running priority |
| act_vld | output | 1 | An interrupt became active last cycle |
| act_id | output | ID_W | Identifier that became active |
| deact_vld | output | 1 | An interrupt is deactivated |
| deact_id | output | ID_W | Identifier being deactivated |

## Verification
The bench builds the unit with its default parameters: a 10-bit identifier and a four-entry stack. The 10-bit identifier puts the special values 1022 and 1023 at the top of the code space. With four entries, four acknowledges of strictly rising group priority fill the stack, so the blocking of a fifth interrupt while full can be checked. The same short run covers the same-cycle pop-then-push case and the drain back to the idle running priority.

// File: rtl/virq_pkg.sv
package virq_pkg;

  localparam int unsigned PRIO_W = 8;
  localparam int unsigned BP_W   = $clog2(PRIO_W);

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [BP_W-1:0]   bp_t;

  typedef struct packed {
    prio_t pmask;
    bp_t   bp0;
    bp_t   bp1;
    logic  cbp;
    logic  g0_fiq;
    logic  ack_g1;
    logic  eoi_split;
    logic  en0;
    logic  en1;
  } vctl_t;

  // keep only the bits above the binary point
  function automatic prio_t group_part(prio_t p, bp_t bp);
    prio_t r;
    for (int i = 0; i < int'(PRIO_W); i++) begin
      r[i] = (i > int'(bp)) ? p[i] : 1'b0;
    end
    return r;
  endfunction

  function automatic bp_t bp_inc_sat(bp_t bp);
    return (bp == '1) ? bp : bp + BP_W'(1);
  endfunction

endpackage

// File: rtl/virq_prio_gate.sv
module virq_prio_gate
  import virq_pkg::*;
#(
  parameter int unsigned ID_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hp_valid,
  input  logic [ID_W-1:0] hp_id,
  input  prio_t           hp_prio,
  input  logic            hp_grp,
  input  vctl_t           ctl,
  input  prio_t           run_prio,
  input  logic            stack_full,
  output logic            eligible,
  output logic            hidden,
  output logic            irq,
  output logic            fiq,
  output logic [ID_W-1:0] resp_id,
  output prio_t           cand_gprio
);

  localparam logic [ID_W-1:0] ID_NONE   = {ID_W{1'b1}};
  localparam logic [ID_W-1:0] ID_HIDDEN = ID_NONE - ID_W'(1);

  bp_t  bp_eff;
  logic grp_en;
  logic above_mask;
  logic preempts;

  always_comb begin
    if (hp_grp) bp_eff = ctl.cbp ? bp_inc_sat(ctl.bp0) : ctl.bp1;
    else        bp_eff = ctl.bp0;
    cand_gprio = group_part(hp_prio, bp_eff);
    grp_en     = hp_grp ? ctl.en1 : ctl.en0;
    above_mask = hp_prio < ctl.pmask;
    preempts   = cand_gprio < run_prio;
    eligible   = hp_valid && grp_en && above_mask && preempts && !stack_full;
    hidden     = eligible && hp_grp && !ctl.ack_g1;
    fiq        = eligible && !hp_grp && ctl.g0_fiq;
    irq        = eligible && (hp_grp || !ctl.g0_fiq);
    if (!eligible)   resp_id = ID_NONE;
    else if (hidden) resp_id = ID_HIDDEN;
    else             resp_id = hp_id;
  end

  a_r3_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq, fiq}));

  a_r1_under_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || fiq) |-> (hp_valid && (hp_prio < ctl.pmask)));

  a_r2_group_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || fiq) |-> (hp_grp ? ctl.en1 : ctl.en0));

  a_r4_hidden_id: assert property (@(posedge clk) disable iff (!rst_n)
    ((resp_id == ID_HIDDEN) && (hp_id != ID_HIDDEN)) |-> (irq && hp_grp && !ctl.ack_g1));

  a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    stack_full |-> (!irq && !fiq && (resp_id == ID_NONE)));

endmodule

// File: rtl/virq_run_stack.sv
module virq_run_stack
  import virq_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  logic  pop,
  input  prio_t push_gprio,
  output prio_t run_prio,
  output logic  full,
  output logic  empty
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]             sp_q;
  logic [CNT_W-1:0]             sp_d;
  logic [CNT_W-1:0]             wr_idx;
  logic                         pop_eff;
  logic [DEPTH-1:0]             we;
  logic [DEPTH-1:0][PRIO_W-1:0] ent_v;

  assign empty = (sp_q == '0);
  assign full  = (sp_q == CNT_W'(DEPTH));

  always_comb begin
    pop_eff = pop && !empty;
    wr_idx  = pop_eff ? sp_q - CNT_W'(1) : sp_q;
    sp_d    = sp_q;
    if (push && !pop_eff)      sp_d = sp_q + CNT_W'(1);
    else if (!push && pop_eff) sp_d = sp_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_ent
    prio_t ent_q;
    assign we[g] = push && (wr_idx == CNT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ent_q <= '1;
      else if (we[g]) ent_q <= push_gprio;
    end
    assign ent_v[g] = ent_q;
  end

  always_comb begin
    run_prio = '1;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (sp_q == CNT_W'(i + 1)) run_prio = ent_v[i];
    end
  end

  a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= CNT_W'(DEPTH));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !(push && !pop));

  a_r6_strict_nesting: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (push_gprio < run_prio));

  a_r7_new_top: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (run_prio == $past(push_gprio)));

  a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);

endmodule

// File: rtl/virq_retire.sv
module virq_retire #(
  parameter int unsigned ID_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [ID_W-1:0] hp_id,
  input  logic            eoi_req,
  input  logic [ID_W-1:0] eoi_id,
  input  logic            dir_req,
  input  logic [ID_W-1:0] dir_id,
  input  logic            eoi_split,
  input  logic            stack_empty,
  output logic            pop,
  output logic            act_vld,
  output logic [ID_W-1:0] act_id,
  output logic            deact_vld,
  output logic [ID_W-1:0] deact_id
);

  logic            eoi_deact;
  logic            dir_deact;
  logic            deact_vld_d;
  logic [ID_W-1:0] deact_id_d;

  always_comb begin
    pop         = eoi_req && !stack_empty;
    eoi_deact   = pop && !eoi_split;
    dir_deact   = dir_req && eoi_split;
    deact_vld_d = eoi_deact || dir_deact;
    deact_id_d  = eoi_deact ? eoi_id : dir_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_vld   <= 1'b0;
      deact_vld <= 1'b0;
    end else begin
      act_vld   <= push;
      deact_vld <= deact_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_id <= '0;
    else if (push) act_id <= hp_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           deact_id <= '0;
    else if (deact_vld_d) deact_id <= deact_id_d;
  end

  a_r7_activate: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (act_vld && (act_id == $past(hp_id))));

  a_r9_combined_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_req && !eoi_split && !stack_empty) |=> (deact_vld && (deact_id == $past(eoi_id))));

  a_r10_split_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_req && eoi_split && !dir_req) |=> !deact_vld);

  a_r10_split_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_req && eoi_split) |=> (deact_vld && (deact_id == $past(dir_id))));

  a_r11_dir_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_req && !eoi_split && !eoi_req) |=> !deact_vld);

endmodule

// File: rtl/virq_ack_unit.sv
module virq_ack_unit
  import virq_pkg::*;
#(
  parameter int unsigned ID_W  = 10,
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hp_valid,
  input  logic [ID_W-1:0]   hp_id,
  input  logic [PRIO_W-1:0] hp_prio,
  input  logic              hp_grp,
  input  logic [PRIO_W-1:0] cfg_pmask,
  input  logic [BP_W-1:0]   cfg_bp0,
  input  logic [BP_W-1:0]   cfg_bp1,
  input  logic              cfg_cbp,
  input  logic              cfg_g0_fiq,
  input  logic              cfg_ack_g1,
  input  logic              cfg_eoi_split,
  input  logic              cfg_en0,
  input  logic              cfg_en1,
  input  logic              ack_req,
  input  logic              eoi_req,
  input  logic [ID_W-1:0]   eoi_id,
  input  logic              dir_req,
  input  logic [ID_W-1:0]   dir_id,
  output logic              irq,
  output logic              fiq,
  output logic [ID_W-1:0]   resp_id,
  output logic [PRIO_W-1:0] run_prio,
  output logic              act_vld,
  output logic [ID_W-1:0]   act_id,
  output logic              deact_vld,
  output logic [ID_W-1:0]   deact_id
);

  logic  rst_meta;
  logic  rst_sync_n;
  vctl_t ctl;
  logic  eligible;
  logic  hidden;
  logic  push;
  logic  pop;
  logic  stack_full;
  logic  stack_empty;
  prio_t cand_gprio;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    ctl.pmask     = cfg_pmask;
    ctl.bp0       = cfg_bp0;
    ctl.bp1       = cfg_bp1;
    ctl.cbp       = cfg_cbp;
    ctl.g0_fiq    = cfg_g0_fiq;
    ctl.ack_g1    = cfg_ack_g1;
    ctl.eoi_split = cfg_eoi_split;
    ctl.en0       = cfg_en0;
    ctl.en1       = cfg_en1;
  end

  assign push = ack_req && eligible && !hidden;

  virq_prio_gate #(.ID_W(ID_W)) u_gate (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .hp_valid   (hp_valid),
    .hp_id      (hp_id),
    .hp_prio    (hp_prio),
    .hp_grp     (hp_grp),
    .ctl        (ctl),
    .run_prio   (run_prio),
    .stack_full (stack_full),
    .eligible   (eligible),
    .hidden     (hidden),
    .irq        (irq),
    .fiq        (fiq),
    .resp_id    (resp_id),
    .cand_gprio (cand_gprio)
  );

  virq_run_stack #(.DEPTH(DEPTH)) u_stack (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .push       (push),
    .pop        (pop),
    .push_gprio (cand_gprio),
    .run_prio   (run_prio),
    .full       (stack_full),
    .empty      (stack_empty)
  );

  virq_retire #(.ID_W(ID_W)) u_retire (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .push        (push),
    .hp_id       (hp_id),
    .eoi_req     (eoi_req),
    .eoi_id      (eoi_id),
    .dir_req     (dir_req),
    .dir_id      (dir_id),
    .eoi_split   (cfg_eoi_split),
    .stack_empty (stack_empty),
    .pop         (pop),
    .act_vld     (act_vld),
    .act_id      (act_id),
    .deact_vld   (deact_vld),
    .deact_id    (deact_id)
  );

  a_r4_hidden_no_push: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ack_req && hidden) |=> !act_vld);

  a_r12_swap_keeps_depth: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (push && pop) |=> (run_prio == $past(cand_gprio)));

endmodule

// File: tb/virq_ack_unit_bench.sv
module virq_ack_unit_bench;

  localparam int ID_W  = 10;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n;
  logic            hp_valid, hp_grp;
  logic [ID_W-1:0] hp_id, eoi_id, dir_id;
  logic [7:0]      hp_prio, cfg_pmask;
  logic [2:0]      cfg_bp0, cfg_bp1;
  logic            cfg_cbp, cfg_g0_fiq, cfg_ack_g1, cfg_eoi_split, cfg_en0, cfg_en1;
  logic            ack_req, eoi_req, dir_req;
  logic            irq, fiq, act_vld, deact_vld;
  logic [ID_W-1:0] resp_id, act_id, deact_id;
  logic [7:0]      run_prio;

  virq_ack_unit #(.ID_W(ID_W), .DEPTH(DEPTH)) u_virq_ack_unit (
    .clk(clk), .rst_n(rst_n), .hp_valid(hp_valid), .hp_id(hp_id), .hp_prio(hp_prio),
    .hp_grp(hp_grp), .cfg_pmask(cfg_pmask), .cfg_bp0(cfg_bp0), .cfg_bp1(cfg_bp1),
    .cfg_cbp(cfg_cbp), .cfg_g0_fiq(cfg_g0_fiq), .cfg_ack_g1(cfg_ack_g1),
    .cfg_eoi_split(cfg_eoi_split), .cfg_en0(cfg_en0), .cfg_en1(cfg_en1),
    .ack_req(ack_req), .eoi_req(eoi_req), .eoi_id(eoi_id), .dir_req(dir_req),
    .dir_id(dir_id), .irq(irq), .fiq(fiq), .resp_id(resp_id), .run_prio(run_prio),
    .act_vld(act_vld), .act_id(act_id), .deact_vld(deact_vld), .deact_id(deact_id)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    due;
    int    kind;
    int    exp;
    string req;
  } exp_t;

  exp_t sb[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 1'b0;

  // independent reference state
  int m_gp[DEPTH];
  int m_sp = 0;

  function automatic int gpart(int p, int bp);
    return (p >> (bp + 1)) << (bp + 1);
  endfunction

  function automatic void expect_at(int due, int kind, int val, string req);
    exp_t e;
    e.due = due; e.kind = kind; e.exp = val; e.req = req;
    sb.push_back(e);
  endfunction

  function automatic int observe(int kind);
    case (kind)
      0: return int'(irq);
      1: return int'(fiq);
      2: return int'(resp_id);
      3: return int'(run_prio);
      4: return int'(act_vld);
      5: return int'(act_id);
      6: return int'(deact_vld);
      default: return int'(deact_id);
    endcase
  endfunction

  function automatic string kname(int kind);
    case (kind)
      0: return "irq";
      1: return "fiq";
      2: return "resp_id";
      3: return "run_prio";
      4: return "act_vld";
      5: return "act_id";
      6: return "deact_vld";
      default: return "deact_id";
    endcase
  endfunction

  // monitor: pops due items and compares away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      int   got;
      e   = sb.pop_front();
      got = observe(e.kind);
      total++;
      if (got != e.exp) begin
        bad++;
        $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", e.req, kname(e.kind), got, e.exp, cyc);
      end
    end
  end

  // driver: applies one cycle of stimulus and queues the expected results
  task automatic step(input int v, input int id, input int pr, input int grp,
                      input int ack, input int eoi, input int eid,
                      input int dir, input int did, input string req);
    int bp, gp, run, en, el, hid, e_fiq, e_irq, resp, pushv, popv, dv, dexp;
    hp_valid = v[0]; hp_id = id[ID_W-1:0]; hp_prio = pr[7:0]; hp_grp = grp[0];
    ack_req = ack[0]; eoi_req = eoi[0]; eoi_id = eid[ID_W-1:0];
    dir_req = dir[0]; dir_id = did[ID_W-1:0];
    if (grp != 0) bp = cfg_cbp ? ((cfg_bp0 == 3'd7) ? 7 : int'(cfg_bp0) + 1) : int'(cfg_bp1);
    else          bp = int'(cfg_bp0);
    gp    = gpart(pr, bp);
    run   = (m_sp == 0) ? 255 : m_gp[m_sp-1];
    en    = (grp != 0) ? int'(cfg_en1) : int'(cfg_en0);
    el    = int'((v != 0) && (en != 0) && (pr < int'(cfg_pmask)) && (gp < run) && (m_sp < DEPTH));
    hid   = int'((el != 0) && (grp != 0) && !cfg_ack_g1);
    e_fiq = int'((el != 0) && (grp == 0) && cfg_g0_fiq);
    e_irq = int'((el != 0) && (e_fiq == 0));
    resp  = (el == 0) ? 1023 : (hid != 0) ? 1022 : id;
    expect_at(cyc, 0, e_irq, req);
    expect_at(cyc, 1, e_fiq, req);
    expect_at(cyc, 2, resp, req);
    pushv = int'((ack != 0) && (el != 0) && (hid == 0));
    popv  = int'((eoi != 0) && (m_sp > 0));
    dv    = int'(((popv != 0) && !cfg_eoi_split) || ((dir != 0) && cfg_eoi_split));
    dexp  = ((popv != 0) && !cfg_eoi_split) ? eid : did;
    if (pushv != 0 && popv != 0) m_gp[m_sp-1] = gp;
    else if (pushv != 0) begin m_gp[m_sp] = gp; m_sp++; end
    else if (popv != 0) m_sp--;
    expect_at(cyc + 1, 3, (m_sp == 0) ? 255 : m_gp[m_sp-1], req);
    expect_at(cyc + 1, 4, pushv, req);
    if (pushv != 0) expect_at(cyc + 1, 5, id, req);
    expect_at(cyc + 1, 6, dv, req);
    if (dv != 0) expect_at(cyc + 1, 7, dexp, req);
    @(posedge clk); #1;
  endtask

  task automatic idle(input string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    rst_n = 1'b0;
    hp_valid = 0; hp_id = '0; hp_prio = '0; hp_grp = 0;
    ack_req = 0; eoi_req = 0; eoi_id = '0; dir_req = 0; dir_id = '0;
    cfg_pmask = 8'h80; cfg_bp0 = 3'd0; cfg_bp1 = 3'd0; cfg_cbp = 0;
    cfg_g0_fiq = 1; cfg_ack_g1 = 1; cfg_eoi_split = 0; cfg_en0 = 1; cfg_en1 = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    idle("R6");                                  // reset state: idle run_prio, no lines
    step(1, 5, 8'h80, 0, 0, 0, 0, 0, 0, "R1");   // equal to mask: blocked
    step(1, 5, 8'h7F, 0, 0, 0, 0, 0, 0, "R1");   // below mask: FIQ
    cfg_g0_fiq = 0;
    step(1, 5, 8'h7F, 0, 0, 0, 0, 0, 0, "R3");   // group 0 on IRQ
    step(1, 9, 8'h20, 1, 0, 0, 0, 0, 0, "R3");   // group 1 on IRQ
    cfg_g0_fiq = 1;
    step(1, 9, 8'h20, 1, 0, 0, 0, 0, 0, "R3");   // group 1 stays on IRQ
    cfg_en0 = 0;
    step(1, 5, 8'h10, 0, 0, 0, 0, 0, 0, "R2");
    cfg_en0 = 1; cfg_en1 = 0;
    step(1, 9, 8'h10, 1, 0, 0, 0, 0, 0, "R2");
    cfg_en1 = 1; cfg_ack_g1 = 0;
    step(1, 9, 8'h10, 1, 1, 0, 0, 0, 0, "R4");   // hidden ack: 1022, no push
    idle("R4");
    cfg_ack_g1 = 1; cfg_bp0 = 3'd2;
    step(1, 40, 8'h65, 0, 1, 0, 0, 0, 0, "R7");  // push 0x60
    step(1, 41, 8'h61, 0, 0, 0, 0, 0, 0, "R6");  // same group prio: no preempt
    step(1, 42, 8'h5F, 0, 0, 0, 0, 0, 0, "R5");  // bp0=2 -> 0x58
    cfg_bp1 = 3'd5;
    step(1, 48, 8'h4F, 1, 0, 0, 0, 0, 0, "R5");  // bp1=5 -> 0x40
    cfg_cbp = 1;
    step(1, 43, 8'h5F, 1, 1, 0, 0, 0, 0, "R5");  // common bp 3 -> 0x50 pushed
    step(1, 44, 8'h3F, 0, 1, 0, 0, 0, 0, "R7");  // 0x38
    step(1, 45, 8'h2F, 0, 1, 0, 0, 0, 0, "R8");  // 0x28, stack full
    step(1, 46, 8'h00, 0, 1, 0, 0, 0, 0, "R8");  // full blocks
    step(0, 0, 0, 0, 0, 1, 45, 0, 0, "R9");      // combined eoi
    step(1, 47, 8'h30, 0, 1, 1, 44, 0, 0, "R12"); // pop then push
    cfg_eoi_split = 1;
    step(0, 0, 0, 0, 0, 1, 47, 0, 0, "R10");     // drop only
    step(0, 0, 0, 0, 0, 0, 0, 1, 47, "R10");     // deactivate
    step(0, 0, 0, 0, 0, 1, 43, 1, 100, "R10");   // both together
    cfg_eoi_split = 0;
    step(0, 0, 0, 0, 0, 0, 0, 1, 9, "R11");      // dir ignored
    step(0, 0, 0, 0, 0, 1, 40, 0, 0, "R9");      // last pop
    step(0, 0, 0, 0, 0, 1, 3, 0, 0, "R11");      // eoi on empty ignored
    cfg_bp0 = 3'd7;
    step(1, 50, 8'h01, 1, 1, 0, 0, 0, 0, "R5");  // saturated bp -> 0
    step(1, 51, 8'h00, 0, 0, 0, 0, 0, 0, "R6");  // 0 not below 0
    step(0, 0, 0, 0, 0, 1, 50, 0, 0, "R9");
    idle("R6");
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule